// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Performance Counters

The block is a read-only, direct-mapped instruction cache for a fetch unit that issues 32-bit byte addresses of 4-byte instructions. It holds 32 instruction words in total, organised either as 32 one-word lines or as 8 four-word lines, chosen by a parameter. A lookup that hits returns the instruction in the same cycle. A lookup that misses stalls the fetch. The cache then asks a backing memory for the whole line that contains the missed word, writes the returned words into the line and finishes the fetch as soon as the line is complete.

Three 64-bit counters accumulate completed hits, completed misses and a nominal cycle total. The cycle total charges one cycle per hit and a fixed parameter cost per miss, so a bench can read the cache's cycles per instruction directly from the ports. That cost is 7 cycles for four-word lines and 5 cycles for one-word lines. A new line always replaces the line at its index, so two addresses that are a cache size (128 bytes) apart keep evicting each other.

Top module: `icache_dm`

## Requirements
- R1: Synchronous reset clears every line's valid bit and zeroes all three counters. After reset, the first fetch of any line is a miss.
- R2: With W words per line, address bits [6:2] pick the word slot and bits [6:2+log2 W] pick the line. The 25 bits [31:7] form the tag. Bits [1:0] take no part in the lookup, so addr and addr|3 return the same word.
- R3: On a miss the cache raises mem_req_valid with mem_req_addr equal to the byte address of the missed line, whose lowest 2+log2 W bits are zero.
- R4: On a miss, fetch_ready stays low until the last word of the line has been written. It then rises in the next cycle while the fetch address is held, so a miss with a memory that answers without gaps stalls for at least W+2 cycles.
- R5: After a fill, fetches of the other words of the same line hit.
- R6: A fill replaces the line at its index. Addresses 128 bytes apart, fetched in turn, miss every time.
- R7: In the idle state, a fetch that hits has fetch_ready high in the same cycle and completes at that clock edge.
- R8: hit_count grows by one for each fetch completed as a hit. miss_count grows by one for each fetch completed after a fill.
- R9: cycle_count grows by 1 for each hit and by MISS_COST for each miss. MISS_COST defaults to 7 with four-word lines and to 5 with one-word lines.
- R10: Response beats carry line words in increasing offset order, starting at offset 0. fetch_instr equals the memory word at addr with bits [1:0] cleared.
- R11: While mem_req_valid is high and mem_req_ready is low, the request stays raised and mem_req_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch completes at this edge; instruction valid |
| fetch_instr | output | 32 | Returned instruction |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_addr | output | 32 | Line-aligned byte address of the fill |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_rsp_valid | input | 1 | One line word on mem_rsp_data |
| mem_rsp_data | input | 32 | Fill word, offsets in increasing order |
| hit_count | output | 64 | Completed hits |
| miss_count | output | 64 | Completed misses |
| cycle_count | output | 64 | Nominal fetch cycles |

## Verification
The assertions assume that the requester holds fetch_valid and fetch_addr steady from the start of a miss until fetch_ready rises. They also assume that the memory sends exactly W response beats only after it has accepted a request, and that fetch_valid is low during reset. The bench's fetch task drives a new address only after the previous fetch has completed. Its memory responder answers only a raised request, with random gaps, and counts out exactly one line of beats. Random addresses come from two regions that share indices, so hits, compulsory misses and conflict evictions all occur in one run.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RECV = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
        logic [CNT_W-1:0] cycles;
    } perf_cnt_t;

    // nominal cost of a miss for a given line length in words
    function automatic int miss_cost(input int words);
        return (words == 1) ? 5 : (3 + words);
    endfunction

    function automatic int bits_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/icache_store.sv
module icache_store
    import icache_pkg::*;
#(
    parameter int CACHE_WORDS = 32,
    parameter int WPL         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [29:0]       lk_waddr,
    output logic              lk_hit,
    output logic [WORD_W-1:0] lk_data,
    input  logic [29:0]       fill_waddr,
    input  logic              inval_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_en
);
    localparam int WADDR_W = $clog2(CACHE_WORDS);
    localparam int LINES   = CACHE_WORDS / WPL;
    localparam int OFFS_W  = $clog2(WPL);
    localparam int IDX_W   = bits_min1(LINES);
    localparam int TAG_W   = 30 - WADDR_W;

    logic [LINES-1:0]        valid_q;
    logic [TAG_W-1:0]        tag_q  [LINES];
    logic [WORD_W-1:0]       data_q [CACHE_WORDS];

    logic [WADDR_W-1:0] lk_slot, fl_slot;
    logic [IDX_W-1:0]   lk_line, fl_line;

    always_comb begin
        lk_slot = lk_waddr[WADDR_W-1:0];
        fl_slot = fill_waddr[WADDR_W-1:0];
        lk_line = IDX_W'(lk_slot >> OFFS_W);
        fl_line = IDX_W'(fl_slot >> OFFS_W);
        lk_hit  = valid_q[lk_line] && (tag_q[lk_line] == lk_waddr[29:WADDR_W]);
        lk_data = data_q[lk_slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inval_en) begin
            valid_q[fl_line] <= 1'b0;
        end else if (set_en) begin
            valid_q[fl_line] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[fl_line] <= fill_waddr[29:WADDR_W];
        end
        if (wr_en) begin
            data_q[fl_slot] <= wr_data;
        end
    end

    AST_COLD_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit); // R1

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int WPL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    input  logic              lk_hit,
    output logic              done,
    output logic              done_miss,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic [29:0]       fill_waddr,
    output logic              inval_en,
    output logic              wr_en,
    output logic              set_en
);
    localparam int BEAT_W = bits_min1(WPL);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(WPL * 4 - 1);

    fill_state_e       state_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] base_q;
    logic              pend_q;
    logic              start_fill;

    always_comb begin
        start_fill    = (state_q == ST_IDLE) && fetch_valid && !lk_hit;
        fetch_ready   = (state_q == ST_IDLE) && lk_hit;
        done          = fetch_valid && fetch_ready;
        done_miss     = done && pend_q;
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = base_q;
        wr_en         = (state_q == ST_RECV) && mem_rsp_valid;
        set_en        = wr_en && (beat_q == BEAT_W'(WPL - 1));
        inval_en      = start_fill;
        fill_waddr    = start_fill ? fetch_addr[31:2] : (base_q[31:2] + 30'(beat_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_fill) begin
                        state_q <= ST_REQ;
                        base_q  <= fetch_addr & ~LINE_MASK;
                        pend_q  <= 1'b1;
                    end else if (done) begin
                        pend_q  <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_RECV;
                        beat_q  <= '0;
                    end
                end
                ST_RECV: begin
                    if (wr_en) begin
                        beat_q <= beat_q + 1'b1;
                        if (set_en) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> ((mem_req_addr & LINE_MASK) == '0)); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11

    AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        $past(set_en) && fetch_valid && $past(fetch_valid) && $stable(fetch_addr)
        |-> fetch_ready); // R4

endmodule

// File: rtl/icache_perf.sv
module icache_perf
    import icache_pkg::*;
#(
    parameter int MISS_COST = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  logic      done_miss,
    output perf_cnt_t cnt
);
    perf_cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (done) begin
            if (done_miss) begin
                cnt_q.misses <= cnt_q.misses + 1'b1;
                cnt_q.cycles <= cnt_q.cycles + CNT_W'(MISS_COST);
            end else begin
                cnt_q.hits   <= cnt_q.hits + 1'b1;
                cnt_q.cycles <= cnt_q.cycles + 1'b1;
            end
        end
    end

    assign cnt = cnt_q;

    AST_ONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> (cnt_q.hits + cnt_q.misses) ==
                        ($past(cnt_q.hits) + $past(cnt_q.misses) + 1)); // R8

    AST_CYCLE_SUM: assert property (@(posedge clk) disable iff (rst)
        cnt_q.cycles == cnt_q.hits + cnt_q.misses * CNT_W'(MISS_COST)); // R9

endmodule

// File: rtl/icache_dm.sv
module icache_dm
    import icache_pkg::*;
#(
    parameter int CACHE_WORDS = 32,
    parameter int WPL         = 4,
    parameter int MISS_COST   = miss_cost(WPL)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    output logic        fetch_ready,
    output logic [31:0] fetch_instr,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic [63:0] hit_count,
    output logic [63:0] miss_count,
    output logic [63:0] cycle_count
);
    logic        lk_hit, done, done_miss;
    logic        inval_en, wr_en, set_en;
    logic [29:0] fill_waddr;
    perf_cnt_t   cnt;

    icache_store #(.CACHE_WORDS(CACHE_WORDS), .WPL(WPL)) u_store (
        .clk        (clk),
        .rst        (rst),
        .lk_waddr   (fetch_addr[31:2]),
        .lk_hit     (lk_hit),
        .lk_data    (fetch_instr),
        .fill_waddr (fill_waddr),
        .inval_en   (inval_en),
        .wr_en      (wr_en),
        .wr_data    (mem_rsp_data),
        .set_en     (set_en)
    );

    icache_fill_ctrl #(.WPL(WPL)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_ready   (fetch_ready),
        .lk_hit        (lk_hit),
        .done          (done),
        .done_miss     (done_miss),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .fill_waddr    (fill_waddr),
        .inval_en      (inval_en),
        .wr_en         (wr_en),
        .set_en        (set_en)
    );

    icache_perf #(.MISS_COST(MISS_COST)) u_perf (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .done_miss (done_miss),
        .cnt       (cnt)
    );

    assign hit_count   = cnt.hits;
    assign miss_count  = cnt.misses;
    assign cycle_count = cnt.cycles;

endmodule

// File: tb/tb_icache_dm.sv
`timescale 1ns/1ps
module tb_icache_dm;
    localparam int WPL  = 4;
    localparam int COST = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic        fetch_ready;
    logic [31:0] fetch_instr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic [63:0] hit_count, miss_count, cycle_count;

    always #10 clk = ~clk;

    icache_dm dut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_instr(fetch_instr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .hit_count(hit_count), .miss_count(miss_count), .cycle_count(cycle_count)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    longint      exp_hits = 0;
    longint      exp_miss = 0;
    logic [31:0] cur_line = '0;
    logic        ref_valid [8];
    logic [24:0] ref_tag   [8];
    bit          finished = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder: one line of beats per accepted request
    initial begin
        logic [31:0] a;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                a = mem_req_addr;
                chk(a == cur_line, "R3", "fill line address", a, cur_line);
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    chk(mem_req_valid && mem_req_addr == a, "R11", "held request",
                        {mem_req_valid, mem_req_addr}, {1'b1, a});
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int i = 0; i < WPL; i++) begin
                    repeat ($urandom % 3) @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(a + 32'(4 * i));
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    // one fetch; called at a negative edge, returns at a negative edge
    task automatic fetch(input logic [31:0] a, output int stalls);
        int  idx;
        bit  exp_hit;
        idx      = int'(a[6:4]);
        exp_hit  = ref_valid[idx] && ref_tag[idx] == a[31:7];
        cur_line = a & ~32'hF;
        fetch_valid = 1'b1;
        fetch_addr  = a;
        stalls = 0;
        #1;
        while (!fetch_ready) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        chk(fetch_instr == mem_word(a & ~32'h3), "R10", "instruction", fetch_instr,
            mem_word(a & ~32'h3));
        if (exp_hit) begin
            chk(stalls == 0, "R7", "hit stall cycles", stalls, 0);
            exp_hits++;
        end else begin
            chk(stalls >= WPL + 2, "R4", "miss stall cycles", stalls, WPL + 2);
            exp_miss++;
        end
        ref_valid[idx] = 1'b1;
        ref_tag[idx]   = a[31:7];
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic check_counters(input string when);
        chk(hit_count == 64'(exp_hits), "R8", {when, " hits"}, hit_count, 64'(exp_hits));
        chk(miss_count == 64'(exp_miss), "R8", {when, " misses"}, miss_count, 64'(exp_miss));
        chk(cycle_count == 64'(exp_hits + COST * exp_miss), "R9", {when, " cycles"},
            cycle_count, 64'(exp_hits + COST * exp_miss));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        logic [31:0] base;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            ref_valid[i] = 1'b0;
            ref_tag[i]   = '0;
        end
        rst = 1'b1;
        fetch_valid = 1'b0;
        fetch_addr  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(hit_count == 0 && miss_count == 0 && cycle_count == 0, "R1", "counters after reset",
            hit_count | miss_count | cycle_count, 0);
        fetch_addr = 32'h98F0_0C64;
        #1;
        chk(fetch_ready == 1'b0, "R1", "cold line ready", fetch_ready, 0);

        base = 32'h98F0_0C60;
        fetch(base + 32'h4, s);
        chk(s > 0, "R1", "first fetch misses", s, 1);
        // R5: other words of the line hit
        fetch(base + 32'h8, s);
        chk(s == 0, "R5", "word 2 of filled line", s, 0);
        fetch(base + 32'hC, s);
        chk(s == 0, "R5", "word 3 of filled line", s, 0);
        fetch(base, s);
        chk(s == 0, "R5", "word 0 of filled line", s, 0);
        // R2: low address bits ignored
        fetch(base + 32'h7, s);
        chk(s == 0, "R2", "unaligned bits ignored", s, 0);
        // R6: conflicting lines 128 bytes apart
        fetch(base + 32'h80, s);
        chk(s > 0, "R6", "conflict line misses", s, 1);
        fetch(base, s);
        chk(s > 0, "R6", "evicted line misses again", s, 1);
        fetch(base + 32'h80, s);
        chk(s > 0, "R6", "ping-pong misses", s, 1);
        // R2: different index, same tag, no conflict
        fetch(base + 32'h10, s);
        fetch(base + 32'h80, s);
        chk(s == 0, "R2", "other index keeps line", s, 0);
        check_counters("directed");

        // random mix over two overlapping regions
        for (int n = 0; n < 500; n++) begin
            logic [31:0] a;
            if ($urandom % 5 == 0)
                a = 32'h98F0_0F00 + 32'(($urandom % 48) * 4);
            else
                a = 32'h98F0_0C00 + 32'(($urandom % 80) * 4);
            if ($urandom % 7 == 0) a = a | 32'($urandom % 4);
            fetch(a, s);
            if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
        end
        check_counters("random");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule